// File: doc/BRIEF.md
# Shift-Register Divider Ratio Encoder

This block turns three integer clock-multiplier ratios (a feedback ratio M, an input pre-divide ratio N and an output post-divide ratio P) into the state codes that divider counters built from linear feedback shift registers load. Each code is the register state reached by stepping a fixed seed a ratio-dependent number of times. The three smallest ratios take fixed codes and skip the stepping. Alongside the M code the block derives two loop-bandwidth selects, a proportional one and an integral one, and packs everything into a feedback word and a divide word. These words are ready to be written into a synthesizer's configuration.

A single-cycle `start` captures the three ratios. All three shift registers then advance together, one step per clock. At the same time a small restoring divider works out the quotient that the integral select needs, so no combinational divide is required. When every lane and the divider have finished, `done` pulses for one cycle. The outputs then hold their values until the next accepted start. A start that arrives while an encoding is running is ignored.

Top module: `lfsr_ratio_encoder`

## Requirements
- R1: The M code is a 15-bit register seeded at 0x4000. Each step shifts it right by one, and the new bit 14 is the XOR of the old bits 0 and 1. For 3 <= M <= 32768 it is stepped 32769-M times. For M above 32768 it stays at the seed. `mCode` is this state zero-extended to 17 bits.
- R2: The N code is an 8-bit register seeded at 0x80. Each step shifts it right, and the new bit 7 is the XOR of the old bits 0, 2, 3 and 4. For 3 <= N <= 256 it is stepped 257-N times. For N above 256 it stays at the seed. `nCode` is 10 bits wide.
- R3: The P code is a 5-bit register seeded at 0x10. Each step shifts it right, and the new bit 4 is the XOR of the old bits 0 and 2. For 3 <= P it is stepped 513-P times. `pCode` is 7 bits wide.
- R4: Fixed codes apply to the smallest ratios:
  - M=1 gives 0x18003 and M=2 gives 0x10003.
  - N=1 gives 0x302 and N=2 gives 0x202.
  - P=1 gives 0x62 and P=2 gives 0x42.
  - A ratio of 0 gives all ones across that code's width.
- R5: `selProp` is (M>>1)+1 for M < 60 and 31 otherwise.
- R6: `selInt` depends on M:
  - 1 if M > 16384
  - 2 if M > 8192
  - 4 if M > 2048
  - 8 if M >= 501
  - 4*floor(1024/(M+9)) if M >= 60
  - (M & 0x3C)+4 otherwise
- R7: `fbWord` holds `mCode` at bit 0, `selProp` at bits 21:17 and `selInt` at bits 27:22, with zeros above. `npWord` holds `nCode` at bits 21:12 and `pCode` at bits 6:0, with zeros elsewhere.
- R8: `done` is high for exactly one cycle. It rises on the clock edge that is max(sM, sN, sP, 11)+1 edges after the edge that accepted `start`, where sX is the step count of R1 to R3 (0 for a fixed code).
- R9: A `start` raised while an encoding is in progress has no effect. The results and the timing of `done` are those of the first request.
- R10: After reset, `done` is 0, `mCode` is 0x4000, `nCode` is 0x80 and `pCode` is 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle request; captures the ratios when idle |
| mRatio | input | 16 | Feedback ratio M |
| nRatio | input | 9 | Pre-divide ratio N |
| pRatio | input | 6 | Post-divide ratio P |
| mCode | output | 17 | Encoded M state |
| nCode | output | 10 | Encoded N state |
| pCode | output | 7 | Encoded P state |
| selProp | output | 5 | Proportional bandwidth select |
| selInt | output | 6 | Integral bandwidth select |
| fbWord | output | 32 | Packed feedback word |
| npWord | output | 32 | Packed pre/post divide word |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result is due on the same edge: the one max(sM, sN, sP, 11)+1 edges after the accepting edge. The divider's eleven steps set the floor when all three ratios take fixed codes. The bench works out this count from the ratios alone. It counts edges, sampling one time unit after each, until `done` is seen, then compares the count and reads every code, select and packed word in that same cycle. One edge later it confirms that `done` has dropped. For the ignored-start case, a second request with other ratios is raised partway through a long run, and the count and the outputs are still judged against the first request.

// File: rtl/lfsr_enc_pkg.sv
package lfsr_enc_pkg;

  typedef struct packed {
    logic load;
    logic run;
  } encStrobe_t;

  localparam int M_CODE_W = 17;
  localparam int N_CODE_W = 10;
  localparam int P_CODE_W = 7;
  localparam int SELP_W   = 5;
  localparam int SELI_W   = 6;

  localparam int M_LFSR_W = 15;
  localparam int N_LFSR_W = 8;
  localparam int P_LFSR_W = 5;

  localparam int M_LIMIT = 32768;
  localparam int N_LIMIT = 256;
  localparam int P_LIMIT = 512;

  localparam int DIVIDEND   = 1024;
  localparam int DIVIDEND_W = 11;

endpackage

// File: rtl/enc_lfsr_lane.sv
module enc_lfsr_lane #(
  parameter int RW = 8,
  parameter int LW = 8,
  parameter int CW = 10,
  parameter logic [LW-1:0] SEED = '0,
  parameter logic [LW-1:0] TAPS = '0,
  parameter int LIMIT = 256,
  parameter logic [CW-1:0] CODE1 = '0,
  parameter logic [CW-1:0] CODE2 = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic          run,
  input  logic [RW-1:0] ratio,
  output logic [CW-1:0] code,
  output logic          fin
);
  localparam int CLOG = $clog2(LIMIT + 2);
  localparam int CNTW = (RW > CLOG) ? RW : CLOG;
  localparam logic [CNTW-1:0] CNT_END = CNTW'(LIMIT);

  typedef enum logic [1:0] {K_ZERO, K_ONE, K_TWO, K_RUN} kind_t;

  kind_t           kind;
  logic [LW-1:0]   lfsr;
  logic [CNTW-1:0] cnt;

  assign fin = (kind != K_RUN) || (cnt > CNT_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kind <= K_RUN;
      lfsr <= SEED;
      cnt  <= CNT_END + CNTW'(1);
    end else if (load) begin
      lfsr <= SEED;
      cnt  <= CNTW'(ratio);
      if (ratio == RW'(0))      kind <= K_ZERO;
      else if (ratio == RW'(1)) kind <= K_ONE;
      else if (ratio == RW'(2)) kind <= K_TWO;
      else                      kind <= K_RUN;
    end else if (run && !fin) begin
      lfsr <= {^(lfsr & TAPS), lfsr[LW-1:1]};
      cnt  <= cnt + CNTW'(1);
    end
  end

  always_comb begin
    case (kind)
      K_ZERO:  code = '1;
      K_ONE:   code = CODE1;
      K_TWO:   code = CODE2;
      default: code = CW'(lfsr);
    endcase
  end

  // R9: without a load nothing moves the register when the lane is not running
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !run) |=> $stable(lfsr));

  // R4: a fixed-code lane never steps
  p_fixed_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (kind != K_RUN && !load) |=> ($stable(lfsr) && $stable(cnt)));

endmodule

// File: rtl/enc_datapath.sv
module enc_datapath
  import lfsr_enc_pkg::*;
#(
  parameter int MW = 16,
  parameter int NW = 9,
  parameter int PW = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  encStrobe_t          strobes,
  input  logic [MW-1:0]       mRatio,
  input  logic [NW-1:0]       nRatio,
  input  logic [PW-1:0]       pRatio,
  output logic [M_CODE_W-1:0] mCode,
  output logic [N_CODE_W-1:0] nCode,
  output logic [P_CODE_W-1:0] pCode,
  output logic [SELP_W-1:0]   selProp,
  output logic [SELI_W-1:0]   selInt,
  output logic [31:0]         fbWord,
  output logic [31:0]         npWord,
  output logic                allFin
);
  localparam int DIVW = MW + 1;
  localparam int DCW  = $clog2(DIVIDEND_W + 1);
  localparam logic [MW-1:0] TH_A = MW'(16384);
  localparam logic [MW-1:0] TH_B = MW'(8192);
  localparam logic [MW-1:0] TH_C = MW'(2048);
  localparam logic [MW-1:0] TH_D = MW'(501);
  localparam logic [MW-1:0] TH_E = MW'(60);

  logic mFin, nFin, pFin;

  enc_lfsr_lane #(.RW(MW), .LW(M_LFSR_W), .CW(M_CODE_W), .SEED(15'h4000),
    .TAPS(15'h0003), .LIMIT(M_LIMIT), .CODE1(17'h18003), .CODE2(17'h10003))
  uLaneM (.clk(clk), .rstN(rstN), .load(strobes.load), .run(strobes.run),
    .ratio(mRatio), .code(mCode), .fin(mFin));

  enc_lfsr_lane #(.RW(NW), .LW(N_LFSR_W), .CW(N_CODE_W), .SEED(8'h80),
    .TAPS(8'h1D), .LIMIT(N_LIMIT), .CODE1(10'h302), .CODE2(10'h202))
  uLaneN (.clk(clk), .rstN(rstN), .load(strobes.load), .run(strobes.run),
    .ratio(nRatio), .code(nCode), .fin(nFin));

  enc_lfsr_lane #(.RW(PW), .LW(P_LFSR_W), .CW(P_CODE_W), .SEED(5'h10),
    .TAPS(5'h05), .LIMIT(P_LIMIT), .CODE1(7'h62), .CODE2(7'h42))
  uLaneP (.clk(clk), .rstN(rstN), .load(strobes.load), .run(strobes.run),
    .ratio(pRatio), .code(pCode), .fin(pFin));

  // restoring divider: DIVIDEND / (M + 9), one quotient bit per clock
  logic [MW-1:0]         mReg;
  logic [DIVIDEND_W-1:0] dvd;
  logic [DIVIDEND_W-1:0] quo;
  logic [DIVW-1:0]       rem;
  logic [DIVW-1:0]       dsr;
  logic [DCW-1:0]        divCnt;
  logic [DIVW-1:0]       remShift;
  logic                  fits;

  assign remShift = {rem[DIVW-2:0], dvd[DIVIDEND_W-1]};
  assign fits     = remShift >= dsr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReg   <= '0;
      dvd    <= '0;
      quo    <= '0;
      rem    <= '0;
      dsr    <= DIVW'(9);
      divCnt <= '0;
    end else if (strobes.load) begin
      mReg   <= mRatio;
      dvd    <= DIVIDEND_W'(DIVIDEND);
      quo    <= '0;
      rem    <= '0;
      dsr    <= {1'b0, mRatio} + DIVW'(9);
      divCnt <= DCW'(DIVIDEND_W);
    end else if (strobes.run && divCnt != '0) begin
      rem    <= fits ? (remShift - dsr) : remShift;
      quo    <= {quo[DIVIDEND_W-2:0], fits};
      dvd    <= {dvd[DIVIDEND_W-2:0], 1'b0};
      divCnt <= divCnt - DCW'(1);
    end
  end

  assign allFin = mFin && nFin && pFin && (divCnt == '0);

  always_comb begin
    if (mReg < TH_E) selProp = SELP_W'(mReg >> 1) + SELP_W'(1);
    else             selProp = SELP_W'(31);
  end

  always_comb begin
    if (mReg > TH_A)       selInt = SELI_W'(1);
    else if (mReg > TH_B)  selInt = SELI_W'(2);
    else if (mReg > TH_C)  selInt = SELI_W'(4);
    else if (mReg >= TH_D) selInt = SELI_W'(8);
    else if (mReg >= TH_E) selInt = {quo[3:0], 2'b00};
    else                   selInt = {mReg[5:2], 2'b00} + SELI_W'(4);
  end

  assign fbWord = {4'b0000, selInt, selProp, mCode};
  assign npWord = {10'b0, nCode, 12'b0} | {25'b0, pCode};

  // R6: once the divider has finished it stays finished until the next load
  p_div_settled_r6: assert property (@(posedge clk) disable iff (!rstN)
    (divCnt == '0 && !strobes.load) |=> (divCnt == '0));

  // R5: the proportional select is never zero
  p_selprop_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    selProp != '0);

endmodule

// File: rtl/enc_ctrl.sv
module enc_ctrl
  import lfsr_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       allFin,
  output encStrobe_t strobes,
  output logic       done
);
  logic busy;

  assign strobes.load = start && !busy;
  assign strobes.run  = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy <= 1'b1;
      end else if (busy && allFin) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: completion only follows a running encoding
  p_done_after_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));

  // R9: an unfinished encoding keeps running whatever start does
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !allFin) |=> busy);

endmodule

// File: rtl/lfsr_ratio_encoder.sv
module lfsr_ratio_encoder
  import lfsr_enc_pkg::*;
#(
  parameter int MW = 16,
  parameter int NW = 9,
  parameter int PW = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [MW-1:0]       mRatio,
  input  logic [NW-1:0]       nRatio,
  input  logic [PW-1:0]       pRatio,
  output logic [M_CODE_W-1:0] mCode,
  output logic [N_CODE_W-1:0] nCode,
  output logic [P_CODE_W-1:0] pCode,
  output logic [SELP_W-1:0]   selProp,
  output logic [SELI_W-1:0]   selInt,
  output logic [31:0]         fbWord,
  output logic [31:0]         npWord,
  output logic                done
);
  encStrobe_t strobes;
  logic       allFin;

  enc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .allFin(allFin),
    .strobes(strobes), .done(done)
  );

  enc_datapath #(.MW(MW), .NW(NW), .PW(PW)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .mRatio(mRatio), .nRatio(nRatio), .pRatio(pRatio),
    .mCode(mCode), .nCode(nCode), .pCode(pCode),
    .selProp(selProp), .selInt(selInt),
    .fbWord(fbWord), .npWord(npWord), .allFin(allFin)
  );

endmodule

// File: tb/sim_lfsr_ratio_encoder.sv
module sim_lfsr_ratio_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] mIn = '0;
  logic [8:0]  nIn = '0;
  logic [5:0]  pIn = '0;
  logic [16:0] mCode;
  logic [9:0]  nCode;
  logic [6:0]  pCode;
  logic [4:0]  selProp;
  logic [5:0]  selInt;
  logic [31:0] fbWord, npWord;
  logic        done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_ratio_encoder u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .mRatio(mIn), .nRatio(nIn), .pRatio(pIn),
    .mCode(mCode), .nCode(nCode), .pCode(pCode),
    .selProp(selProp), .selInt(selInt),
    .fbWord(fbWord), .npWord(npWord), .done(done)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] expM(int m);
    logic [14:0] x = 15'h4000;
    if (m == 0) return 17'h1FFFF;
    if (m == 1) return 17'h18003;
    if (m == 2) return 17'h10003;
    for (int i = m; i <= 32768; i++) x = {x[0] ^ x[1], x[14:1]};
    return {2'b00, x};
  endfunction

  function automatic logic [9:0] expN(int n);
    logic [7:0] x = 8'h80;
    if (n == 0) return 10'h3FF;
    if (n == 1) return 10'h302;
    if (n == 2) return 10'h202;
    for (int i = n; i <= 256; i++) x = {x[0] ^ x[2] ^ x[3] ^ x[4], x[7:1]};
    return {2'b00, x};
  endfunction

  function automatic logic [6:0] expP(int p);
    logic [4:0] x = 5'h10;
    if (p == 0) return 7'h7F;
    if (p == 1) return 7'h62;
    if (p == 2) return 7'h42;
    for (int i = p; i <= 512; i++) x = {x[0] ^ x[2], x[4:1]};
    return {2'b00, x};
  endfunction

  function automatic int expSelP(int m);
    return (m < 60) ? (m >> 1) + 1 : 31;
  endfunction

  function automatic int expSelI(int m);
    if (m > 16384) return 1;
    if (m > 8192)  return 2;
    if (m > 2048)  return 4;
    if (m >= 501)  return 8;
    if (m >= 60)   return 4 * (1024 / (m + 9));
    return (m & 'h3C) + 4;
  endfunction

  function automatic int expLat(int m, int n, int p);
    int k = 11;
    int sm = (m >= 3 && m <= 32768) ? 32769 - m : 0;
    int sn = (n >= 3 && n <= 256) ? 257 - n : 0;
    int sp = (p >= 3 && p <= 512) ? 513 - p : 0;
    if (sm > k) k = sm;
    if (sn > k) k = sn;
    if (sp > k) k = sp;
    return k + 1;
  endfunction

  task automatic runOne(int m, int n, int p, bit poke);
    int cyc = 0;
    bit got = 0;
    @(posedge clk); #1;
    mIn = 16'(m); nIn = 9'(n); pIn = 6'(p); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    while (!got && cyc < 40000) begin
      if (poke && cyc == 5) begin
        mIn = 16'd32760; nIn = 9'd200; pIn = 6'd30; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk); #1;
      cyc++;
      if (done) got = 1;
    end
    start = 1'b0;
    chk(poke ? "R9 latency after ignored start" : "R8 latency", cyc, expLat(m, n, p));
    chk("R1/R4 mCode", {15'b0, mCode}, {15'b0, expM(m)});
    chk("R2/R4 nCode", {22'b0, nCode}, {22'b0, expN(n)});
    chk("R3/R4 pCode", {25'b0, pCode}, {25'b0, expP(p)});
    chk("R5 selProp", {27'b0, selProp}, expSelP(m));
    chk("R6 selInt", {26'b0, selInt}, expSelI(m));
    chk("R7 fbWord", fbWord,
        {4'b0, 6'(expSelI(m)), 5'(expSelP(m)), expM(m)});
    chk("R7 npWord", npWord, {10'b0, expN(n), 12'b0} | {25'b0, expP(p)});
    @(posedge clk); #1;
    chk("R8 done pulse ends", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7311));
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset done", {31'b0, done}, 32'd0);
    chk("R10 reset mCode", {15'b0, mCode}, 32'h4000);
    chk("R10 reset nCode", {22'b0, nCode}, 32'h80);
    chk("R10 reset pCode", {25'b0, pCode}, 32'h10);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R4 fixed codes and zero ratios
    runOne(0, 0, 0, 0);
    runOne(1, 1, 1, 0);
    runOne(2, 2, 2, 0);
    // R1 R2 R3 boundaries of the stepped range
    runOne(32768, 256, 32, 0);
    runOne(32767, 3, 3, 0);
    runOne(40000, 300, 33, 0);
    // R5 R6 threshold cases
    runOne(59, 255, 31, 0);
    runOne(500, 17, 5, 0);
    runOne(501, 128, 9, 0);
    runOne(8192, 4, 4, 0);
    // R9 start raised mid-run is ignored
    runOne(16384, 100, 20, 1);

    for (int t = 0; t < 15; t++) begin
      runOne(31000 + int'($urandom_range(1768)), int'($urandom_range(299)),
             int'($urandom_range(40)), 0);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule